// File: doc/BRIEF.md
# Dual-Edge Interval Capture Timer

This block is a free-running up-counter with a power-of-two prescaler and a pair of input capture channels. The counter starts at zero, counts to all ones and wraps back to zero, and each wrap raises an overflow flag. Each capture channel watches an input that first passes through a two-stage synchronizer and a programmable glitch filter. On a qualifying edge the channel copies the counter value into its capture register and sets its flag.

The two channels can be joined into one interval measurement on input 0. Once software arms the pair, the next qualifying edge loads channel 0 and the edge after that loads channel 1. The elapsed time is the difference of the two captures, modulo the counter width. In one-shot mode the arm bit drops as soon as the second capture lands, and no further capture happens until software arms the pair again. In continuous mode the pair keeps measuring back-to-back intervals. Each flag is cleared by a one-cycle write-one-to-clear pulse. A single interrupt line is the OR of every flag that has its enable set.

Top module: `edge_interval_timer`

## Requirements
- R1: After reset the counter, captures, flags, arm state and `irq_o` are all zero. While running, the counter adds one on each prescaled tick and wraps from all ones to zero.
- R2: The counter advances once every 2^`prescale_i` system clocks. A `clk_sel_i` of 2'b00 holds the counter, and any other value lets it run from the system clock.
- R3: The overflow flag sets on the clock on which the counter wraps from all ones to zero.
- R4: With `pair_en_i` low, each channel captures the counter on its own input, using its own edge-select code: 2'b00 none, 2'b01 rising, 2'b10 falling, 2'b11 both. The other channel is not affected.
- R5: With `pair_en_i` high, only `cap_in_i[0]` is used. The first edge selected by `edge_sel0_i` loads `cap0_o` and sets `ch_flag_o[0]`. The next edge selected by `edge_sel1_i` loads `cap1_o` and sets `ch_flag_o[1]`. `cap_in_i[1]` is ignored.
- R6: With `pair_en_i` and `one_shot_i` high, nothing is captured while `armed_o` is low. A one-cycle pulse on `arm_set_i` sets `armed_o`. `armed_o` clears on the same clock that loads `cap1_o` and sets `ch_flag_o[1]`.
- R7: With `pair_en_i` high and `one_shot_i` low, `armed_o` stays set after each second capture, and edges keep alternating between `cap0_o` and `cap1_o`.
- R8: `cap1_o - cap0_o`, taken modulo 2^CNT_W, equals the number of counter ticks between the two edges, even across a wrap, as long as the interval is shorter than one counter period.
- R9: With the prescaler at 1 and a filter length of 0 or 1, a capture holds the counter value seen three clocks after the input change is presented. A filter length L greater than 1 adds L-1 clocks.
- R10: With a filter length L of at least 2, an input pulse that lasts fewer than L clocks is rejected and one that lasts L clocks passes. A length of 0 bypasses the filter.
- R11: Bits 0, 1 and 2 of `flag_clr_i` clear channel flag 0, channel flag 1 and the overflow flag. If a flag's set event falls in the same clock as its clear, the flag stays set.
- R12: `irq_o` is high exactly when some flag is set and that flag's interrupt enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_sel_i | input | 2 | 00 holds the counter; any other value runs it from the system clock |
| prescale_i | input | PS_W | Divide exponent: tick every 2^value clocks |
| filt_len_i | input | FILT_W | Glitch filter length in clocks; 0 bypasses the filter |
| pair_en_i | input | 1 | Joins the two channels into one interval measurement on input 0 |
| one_shot_i | input | 1 | In paired mode, drop the arm state after each second capture |
| arm_set_i | input | 1 | One-cycle pulse that arms a paired measurement |
| edge_sel0_i | input | 2 | Edge code for channel 0 |
| edge_sel1_i | input | 2 | Edge code for channel 1 |
| cap_in_i | input | 2 | Capture inputs, asynchronous |
| ch_ie_i | input | 2 | Channel interrupt enables |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| flag_clr_i | input | 3 | Write-one-to-clear pulses: bit0 ch0, bit1 ch1, bit2 overflow |
| count_o | output | CNT_W | Counter value |
| cap0_o | output | CNT_W | Channel 0 capture register |
| cap1_o | output | CNT_W | Channel 1 capture register |
| ch_flag_o | output | 2 | Channel capture flags |
| ovf_flag_o | output | 1 | Overflow flag |
| armed_o | output | 1 | Paired measurement armed |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the timer with an 8-bit counter, a 2-bit prescale exponent and a 3-bit filter length. The short counter puts wraps a few hundred clocks apart, so overflow, set-over-clear priority and intervals that straddle a wrap all fit in a short run. The small fields let the bench sweep every divide ratio, every edge code and a range of filter lengths. Interval widths are swept up to a full period less one tick at several prescale settings, and the expected differences are worked out from the stimulus timing alone.

// File: rtl/edge_timer_pkg.sv
package edge_timer_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  function automatic logic edge_hit(input edge_sel_e sel, input logic rise, input logic fall);
    return (sel[0] & rise) | (sel[1] & fall);
  endfunction
endpackage

// File: rtl/et_timebase.sv
module et_timebase #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PS_W-1:0]  ps_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  localparam int DIV_W = (1 << PS_W) - 1;
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   one_hot;
  logic [DIV_W-1:0] mask;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  always_comb begin
    one_hot = {{DIV_W{1'b0}}, 1'b1} << ps_i;
    mask    = one_hot[DIV_W-1:0] - DIV_ONE;  // ps at max wraps to all ones
    tick    = run_i && ((div_q & mask) == mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (run_i) begin
      div_q <= div_q + DIV_ONE;
      if (tick) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign count_o = cnt_q;
  assign wrap_o  = tick && (cnt_q == '1);
endmodule

// File: rtl/et_input_cond.sv
module et_input_cond #(
  parameter int FILT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_i,
  input  logic [FILT_W-1:0] filt_len_i,
  output logic              rise_o,
  output logic              fall_o
);
  logic [1:0]        sync_q;
  logic              filt_q;
  logic              prev_q;
  logic [FILT_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      filt_q <= 1'b0;
      prev_q <= 1'b0;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], in_i};
      prev_q <= filt_q;
      if (filt_len_i == '0) begin
        filt_q <= sync_q[1];
        run_q  <= '0;
      end else if (sync_q[1] == filt_q) begin
        run_q <= '0;
      end else if (run_q == filt_len_i - FILT_W'(1)) begin
        filt_q <= sync_q[1];
        run_q  <= '0;
      end else begin
        run_q <= run_q + FILT_W'(1);
      end
    end
  end

  assign rise_o = filt_q & ~prev_q;
  assign fall_o = ~filt_q & prev_q;
endmodule

// File: rtl/et_capture_ctrl.sv
module et_capture_ctrl
  import edge_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wrap_i,
  input  logic [1:0]       rise_i,
  input  logic [1:0]       fall_i,
  input  logic [1:0]       sel0_i,
  input  logic [1:0]       sel1_i,
  input  logic             pair_en_i,
  input  logic             one_shot_i,
  input  logic             arm_set_i,
  input  logic [2:0]       flag_clr_i,
  input  logic [1:0]       ch_ie_i,
  input  logic             ovf_ie_i,
  output logic [CNT_W-1:0] cap0_o,
  output logic [CNT_W-1:0] cap1_o,
  output logic [1:0]       ch_flag_o,
  output logic             ovf_flag_o,
  output logic             armed_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cap0_q, cap1_q;
  logic [1:0]       flag_q;
  logic             ovf_q, armed_q, second_q;
  logic             hit0, hit1_own, hit1_pair, stb0, stb1;

  always_comb begin
    hit0      = edge_hit(edge_sel_e'(sel0_i), rise_i[0], fall_i[0]);
    hit1_own  = edge_hit(edge_sel_e'(sel1_i), rise_i[1], fall_i[1]);
    hit1_pair = edge_hit(edge_sel_e'(sel1_i), rise_i[0], fall_i[0]);
    if (pair_en_i) begin
      stb0 = armed_q && !second_q && hit0;
      stb1 = armed_q &&  second_q && hit1_pair;
    end else begin
      stb0 = hit0;
      stb1 = hit1_own;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap0_q   <= '0;
      cap1_q   <= '0;
      flag_q   <= '0;
      ovf_q    <= 1'b0;
      armed_q  <= 1'b0;
      second_q <= 1'b0;
    end else begin
      if (stb0) cap0_q <= count_i;
      if (stb1) cap1_q <= count_i;
      // set wins over a same-cycle clear
      flag_q <= (flag_q & ~flag_clr_i[1:0]) | {stb1, stb0};
      ovf_q  <= (ovf_q & ~flag_clr_i[2]) | wrap_i;
      if (arm_set_i) begin
        armed_q  <= 1'b1;
        second_q <= 1'b0;
      end else if (pair_en_i) begin
        if (stb0) second_q <= 1'b1;
        else if (stb1) begin
          second_q <= 1'b0;
          if (one_shot_i) armed_q <= 1'b0;
        end
      end
    end
  end

  assign cap0_o     = cap0_q;
  assign cap1_o     = cap1_q;
  assign ch_flag_o  = flag_q;
  assign ovf_flag_o = ovf_q;
  assign armed_o    = armed_q;
  assign irq_o      = (|(flag_q & ch_ie_i)) | (ovf_q & ovf_ie_i);
endmodule

// File: rtl/edge_interval_timer.sv
module edge_interval_timer #(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int FILT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        clk_sel_i,
  input  logic [PS_W-1:0]   prescale_i,
  input  logic [FILT_W-1:0] filt_len_i,
  input  logic              pair_en_i,
  input  logic              one_shot_i,
  input  logic              arm_set_i,
  input  logic [1:0]        edge_sel0_i,
  input  logic [1:0]        edge_sel1_i,
  input  logic [1:0]        cap_in_i,
  input  logic [1:0]        ch_ie_i,
  input  logic              ovf_ie_i,
  input  logic [2:0]        flag_clr_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  cap0_o,
  output logic [CNT_W-1:0]  cap1_o,
  output logic [1:0]        ch_flag_o,
  output logic              ovf_flag_o,
  output logic              armed_o,
  output logic              irq_o
);
  localparam int N_CH = 2;

  logic [CNT_W-1:0] count;
  logic             wrap;
  logic [N_CH-1:0]  rise, fall;

  et_timebase #(.CNT_W(CNT_W), .PS_W(PS_W)) u_timebase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (clk_sel_i != 2'b00),
    .ps_i    (prescale_i),
    .count_o (count),
    .wrap_o  (wrap)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_in
    et_input_cond #(.FILT_W(FILT_W)) u_cond (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_i       (cap_in_i[c]),
      .filt_len_i (filt_len_i),
      .rise_o     (rise[c]),
      .fall_o     (fall[c])
    );
  end

  et_capture_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .count_i    (count),
    .wrap_i     (wrap),
    .rise_i     (rise),
    .fall_i     (fall),
    .sel0_i     (edge_sel0_i),
    .sel1_i     (edge_sel1_i),
    .pair_en_i  (pair_en_i),
    .one_shot_i (one_shot_i),
    .arm_set_i  (arm_set_i),
    .flag_clr_i (flag_clr_i),
    .ch_ie_i    (ch_ie_i),
    .ovf_ie_i   (ovf_ie_i),
    .cap0_o     (cap0_o),
    .cap1_o     (cap1_o),
    .ch_flag_o  (ch_flag_o),
    .ovf_flag_o (ovf_flag_o),
    .armed_o    (armed_o),
    .irq_o      (irq_o)
  );

  assign count_o = count;
endmodule

// File: rtl/edge_interval_timer_chk.sv
module edge_interval_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       clk_sel_i,
  input logic             pair_en_i,
  input logic             one_shot_i,
  input logic             arm_set_i,
  input logic             ovf_clr_i,
  input logic [1:0]       ch_ie_i,
  input logic             ovf_ie_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] cap0_o,
  input logic [CNT_W-1:0] cap1_o,
  input logic [1:0]       ch_flag_o,
  input logic             ovf_flag_o,
  input logic             armed_o,
  input logic             irq_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && count_o != $past(count_o)) |-> (count_o == CNT_W'($past(count_o) + CNT_W'(1))));

  assert_halt_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && clk_sel_i == 2'b00) |=> $stable(count_o));

  assert_ovf_on_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(count_o) == '1 && count_o == '0) |-> ovf_flag_o);

  assert_no_cap_unarmed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && pair_en_i && one_shot_i && !armed_o) |=> ($stable(cap0_o) && $stable(cap1_o)));

  assert_arm_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(pair_en_i && one_shot_i && !arm_set_i) && $rose(ch_flag_o[1])) |-> !armed_o);

  assert_ovf_clear_src_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $fell(ovf_flag_o)) |-> $past(ovf_clr_i));

  assert_irq_masked_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_ie_i == 2'b00 && !ovf_ie_i) |-> !irq_o);

  assert_irq_has_src_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ch_flag_o != 2'b00 || ovf_flag_o));
endmodule

bind edge_interval_timer edge_interval_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clk_sel_i  (clk_sel_i),
  .pair_en_i  (pair_en_i),
  .one_shot_i (one_shot_i),
  .arm_set_i  (arm_set_i),
  .ovf_clr_i  (flag_clr_i[2]),
  .ch_ie_i    (ch_ie_i),
  .ovf_ie_i   (ovf_ie_i),
  .count_o    (count_o),
  .cap0_o     (cap0_o),
  .cap1_o     (cap1_o),
  .ch_flag_o  (ch_flag_o),
  .ovf_flag_o (ovf_flag_o),
  .armed_o    (armed_o),
  .irq_o      (irq_o)
);

// File: tb/edge_interval_timer_bench.sv
`timescale 1ns/1ps
module edge_interval_timer_bench;
  localparam int CNT_W = 8;
  localparam int PS_W = 2;
  localparam int FILT_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] clk_sel = 2'b01;
  logic [PS_W-1:0] ps = '0;
  logic [FILT_W-1:0] filt = '0;
  logic pair_en = 1'b0, one_shot = 1'b1, arm_set = 1'b0;
  logic [1:0] sel0 = 2'b01, sel1 = 2'b01, cap_in = 2'b00, ch_ie = 2'b00;
  logic ovf_ie = 1'b0;
  logic [2:0] flag_clr = 3'b000;
  logic [CNT_W-1:0] count, cap0, cap1;
  logic [1:0] ch_flag;
  logic ovf_flag, armed, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  edge_interval_timer #(.CNT_W(CNT_W), .PS_W(PS_W), .FILT_W(FILT_W)) u_edge_interval_timer (
    .clk_i(clk), .rst_ni(rst_n), .clk_sel_i(clk_sel), .prescale_i(ps), .filt_len_i(filt),
    .pair_en_i(pair_en), .one_shot_i(one_shot), .arm_set_i(arm_set),
    .edge_sel0_i(sel0), .edge_sel1_i(sel1), .cap_in_i(cap_in), .ch_ie_i(ch_ie),
    .ovf_ie_i(ovf_ie), .flag_clr_i(flag_clr), .count_o(count), .cap0_o(cap0),
    .cap1_o(cap1), .ch_flag_o(ch_flag), .ovf_flag_o(ovf_flag), .armed_o(armed), .irq_o(irq));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_flags();
    @(negedge clk); flag_clr = 3'b111;
    @(negedge clk); flag_clr = 3'b000;
  endtask

  task automatic arm();
    @(negedge clk); arm_set = 1'b1;
    @(negedge clk); arm_set = 1'b0;
  endtask

  task automatic wait_count(input int v);
    for (int i = 0; i < 4000 && int'(count) != v; i++) @(negedge clk);
  endtask

  // rising edge on input 0, then the next rise follows `gap` clocks after this one
  task automatic rise_gap(input int gap);
    cap_in[0] = 1'b1; cyc(2);
    cap_in[0] = 1'b0; cyc(gap - 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c;
    cyc(3);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 caps", int'(cap0) + int'(cap1), 0);
    chk("R1 flags", {ch_flag, ovf_flag, armed, irq}, 0);

    // R1/R2 divide sweep
    for (int p = 0; p < 4; p++) begin
      ps = PS_W'(p); cyc(1);
      c = count; cyc(20 << p);
      chk($sformatf("R2 divide ps=%0d", p), (int'(count) - c) & 255, 20);
    end
    ps = '0; cyc(1);
    clk_sel = 2'b00; cyc(1);
    c = count; cyc(40);
    chk("R2 halt", count, c);
    clk_sel = 2'b11; cyc(1);
    c = count; cyc(9);
    chk("R1 run step", (int'(count) - c) & 255, 9);

    // R3/R11/R12 overflow
    ovf_ie = 1'b1; clr_flags();
    wait_count(255); cyc(1);
    chk("R3 wrap count", count, 0);
    chk("R3 ovf set", ovf_flag, 1);
    chk("R12 irq ovf", irq, 1);
    flag_clr = 3'b100; cyc(1); flag_clr = 3'b000;
    chk("R11 clear", ovf_flag, 0);
    wait_count(255); flag_clr = 3'b100; cyc(1); flag_clr = 3'b000;
    chk("R11 set beats clear", ovf_flag, 1);
    ovf_ie = 1'b0; cyc(1);
    chk("R12 masked", irq, 0);
    clr_flags();

    // R9/R10 latency for filter 0,1,3
    pair_en = 1'b0; sel0 = 2'b01; sel1 = 2'b00;
    for (int k = 0; k < 3; k++) begin
      int l;
      l = (k == 2) ? 3 : k;
      filt = FILT_W'(l); clr_flags();
      c = count; cap_in[0] = 1'b1;
      cyc(4 + ((l > 1) ? l - 1 : 0));
      chk($sformatf("R9 latency filt=%0d", l), cap0, (c + 3 + ((l > 1) ? l - 1 : 0)) & 255);
      chk("R9 flag0", ch_flag[0], 1);
      cap_in[0] = 1'b0; cyc(10);
    end
    filt = '0;

    // R4/R12 edge codes on channel 1
    ch_ie = 2'b10;
    for (int s = 0; s < 4; s++) begin
      sel1 = 2'(s); clr_flags();
      cap_in[1] = 1'b1; cyc(8);
      chk($sformatf("R4 rise sel=%0d", s), ch_flag[1], s & 1);
      chk($sformatf("R12 irq sel=%0d", s), irq, s & 1);
      chk("R4 ch0 untouched", ch_flag[0], 0);
      clr_flags();
      cap_in[1] = 1'b0; cyc(8);
      chk($sformatf("R4 fall sel=%0d", s), ch_flag[1], (s >> 1) & 1);
    end
    ch_ie = 2'b00; sel1 = 2'b01;

    // R6 unarmed paired mode ignores edges
    pair_en = 1'b1; one_shot = 1'b1; clr_flags();
    c = {cap1, cap0};
    rise_gap(10); rise_gap(10); cyc(6);
    chk("R6 unarmed flags", ch_flag, 0);
    chk("R6 unarmed caps", {cap1, cap0}, c);

    // R5 input 1 ignored in paired mode
    arm();
    cap_in[1] = 1'b1; cyc(3); cap_in[1] = 1'b0; cyc(8);
    chk("R5 input1 ignored", ch_flag, 0);
    chk("R6 armed", armed, 1);

    // R5/R6/R8 interval sweep
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 4; k++) begin
        int n;
        n = (k == 0) ? 5 : (k == 1) ? 37 : (k == 2) ? 200 : 255;
        ps = PS_W'(p); clr_flags(); arm();
        rise_gap(n << p);
        rise_gap(12 << p);
        chk($sformatf("R8 interval ps=%0d n=%0d", p, n), (int'(cap1) - int'(cap0)) & 255, n);
        chk("R5 flags", ch_flag, 3);
        chk("R6 arm drop", armed, 0);
        c = {cap1, cap0};
        rise_gap(10); rise_gap(10); cyc(4);
        chk("R6 no recapture", {cap1, cap0}, c);
      end
    end

    // R8 interval across a wrap
    ps = '0; clr_flags(); arm();
    wait_count(250);
    rise_gap(100); rise_gap(12);
    chk("R8 wrap order", int'(cap1 < cap0), 1);
    chk("R8 wrap interval", (int'(cap1) - int'(cap0)) & 255, 100);

    // R7 continuous paired mode
    one_shot = 1'b0; clr_flags(); arm();
    rise_gap(10); rise_gap(15);
    chk("R7 first pair", (int'(cap1) - int'(cap0)) & 255, 10);
    chk("R7 still armed", armed, 1);
    rise_gap(7); rise_gap(12);
    chk("R7 second pair", (int'(cap1) - int'(cap0)) & 255, 7);
    chk("R7 armed after", armed, 1);

    // R10 filter sweep
    pair_en = 1'b0; one_shot = 1'b1; sel0 = 2'b01;
    for (int l = 2; l < 6; l++) begin
      filt = FILT_W'(l); clr_flags();
      cap_in[0] = 1'b1; cyc(l - 1); cap_in[0] = 1'b0; cyc(14);
      chk($sformatf("R10 reject L=%0d", l), ch_flag[0], 0);
      cap_in[0] = 1'b1; cyc(l); cap_in[0] = 1'b0; cyc(14);
      chk($sformatf("R10 pass L=%0d", l), ch_flag[0], 1);
    end
    filt = '0; clr_flags();
    cap_in[0] = 1'b1; cyc(1); cap_in[0] = 1'b0; cyc(8);
    chk("R10 bypass", ch_flag[0], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule